// File: doc/BRIEF.md
# Asynchronous Bus Read Master

This block runs read cycles on a classic asynchronous microprocessor-style bus on behalf of an internal client. A request (address, function code, byte/word size) is taken over a valid/ready handshake. The block then walks a fixed sequence of eight half-clock states, S0 to S7. It drives the function code, a read/write line held at read, the address with its output enable, the address strobe and the upper/lower data strobes. It then waits for the slave's asynchronous termination: acknowledge, bus error or peripheral-cycle request.

The block runs from an internal clock at twice the bus rate. Each internal cycle is one half-state, and the bus clock is brought out as a pin that is high in even states. When the acknowledge is late, the block inserts wait states of one full bus clock each. A programmable watchdog ends a cycle that never terminates. The block returns the latched data together with a two-bit status code.

Top module: `bus_read_master`

## Requirements
- R1: `req_ready` is high only while the block is idle and `bus_clk` is low. A request seen with `req_valid` and `req_ready` both high at a clock edge starts a cycle in S0 on the next internal cycle. While a cycle runs, `req_ready` stays low.
- R2: `bus_clk` toggles on every internal clock. It is high in S0, S2, S4 and S6 and in the second half of each wait state, so a read with no wait states lasts four bus clocks.
- R3: `bus_fc` carries the request's function code from S0 through S7 and is 0 when idle. `bus_rw` is always high (read).
- R4: `bus_addr` (address bits above bit 0) is enabled by `bus_addr_oe` from S1 through S7. The enable drops on the internal cycle after S7.
- R5: `bus_as_n` and the selected data strobes are low from S2 through S6, including wait states. All three are high in S7.
- R6: A word read (`req_word`=1) asserts both `bus_uds_n` and `bus_lds_n`. A byte read at an even address asserts only `bus_uds_n`. A byte read at an odd address asserts only `bus_lds_n`.
- R7: `bus_dtack_n`, `bus_berr_n` and `bus_vpa_n` pass through a two-flop synchronizer. They are examined at the end of S4 and at the end of each wait state. Each wait state adds two internal cycles, and the response appears 8 + 2·W internal cycles after the accepting edge, where W is the number of wait states.
- R8: Status encoding: 0 means OK (acknowledge), 1 means bus error, 2 means peripheral cycle not supported. If bus error and acknowledge are seen together, the status is 1.
- R9: A peripheral-cycle request seen at a decision point with neither bus error nor acknowledge ends the cycle with status 2 and data 0.
- R10: If no termination is seen after `wait_limit` wait states, the cycle ends with status 1. A termination present at that last decision point still takes effect.
- R11: Data is latched at the end of S6. A word read returns the full bus word. An even-address byte returns bits 15:8 in bits 7:0, an odd-address byte returns bits 7:0, and the upper bits are 0. Any status other than OK returns 0.
- R12: `rsp_valid` is a one-cycle pulse, raised on the internal cycle after S7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Byte address of the read |
| req_fc | input | 3 | Function code for the cycle |
| req_word | input | 1 | 1 = word read, 0 = byte read |
| wait_limit | input | WW | Wait states allowed before the watchdog ends the cycle |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | DW | Returned data |
| rsp_status | output | 2 | 0 OK, 1 bus error, 2 peripheral unsupported |
| bus_clk | output | 1 | Bus clock |
| bus_fc | output | 3 | Bus function code |
| bus_rw | output | 1 | Read/write line, high for read |
| bus_addr | output | AW-1 | Address bits AW-1 to 1 |
| bus_addr_oe | output | 1 | Address output enable |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper data strobe, active low |
| bus_lds_n | output | 1 | Lower data strobe, active low |
| bus_data_in | input | DW | Data bus from the slave |
| bus_dtack_n | input | 1 | Acknowledge, active low, asynchronous |
| bus_berr_n | input | 1 | Bus error, active low, asynchronous |
| bus_vpa_n | input | 1 | Peripheral-cycle request, active low, asynchronous |

## Verification
A slave model raises its termination D internal cycles after it first sees the address strobe low. The synchronizer then makes the wait count ceil(D/2), capped by `wait_limit`, so the bench expects the response exactly 8 + 2·W cycles after acceptance. It counts falling edges from the accepting edge and checks `rsp_valid` on the 9 + 2·W'th. On that same edge it checks data and status, and on the edge before it checks the S7 levels of strobe and address enable. Strobes, address and function code are captured on the first half-cycle the address strobe is low. The pulse width is confirmed one half-cycle after the response.

// File: rtl/brm_pkg.sv
package brm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4,
    ST_S5, ST_S6, ST_S7, ST_WL, ST_WH
  } brm_state_e;

  typedef enum logic [1:0] {
    RSP_OK     = 2'd0,
    RSP_BERR   = 2'd1,
    RSP_PERIPH = 2'd2
  } brm_rsp_e;

  // Active-high strobe enables {upper, lower} for a read.
  function automatic logic [1:0] strobe_pick(input logic word, input logic a0);
    if (word) return 2'b11;
    return a0 ? 2'b01 : 2'b10;
  endfunction

  // Bus clock level that belongs to a state.
  function automatic logic phase_high(input brm_state_e st);
    return (st == ST_S0) || (st == ST_S2) || (st == ST_S4) ||
           (st == ST_S6) || (st == ST_WH);
  endfunction

  // Strobes active from S2 through S6, wait states included.
  function automatic logic strobe_window(input brm_state_e st);
    return (st == ST_S2) || (st == ST_S3) || (st == ST_S4) || (st == ST_S5) ||
           (st == ST_S6) || (st == ST_WL) || (st == ST_WH);
  endfunction

  // Termination priority: error, acknowledge, peripheral, watchdog.
  function automatic brm_rsp_e term_status(input logic err, input logic ack,
                                           input logic vpa);
    if (err) return RSP_BERR;
    if (ack) return RSP_OK;
    if (vpa) return RSP_PERIPH;
    return RSP_BERR;
  endfunction

endpackage

// File: rtl/brm_sync.sv
module brm_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[s] <= '1;
      else if (s == 0) stage_q[s] <= d;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/brm_wait_timer.sv
module brm_wait_timer #(
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [WW-1:0] limit,
  output logic          expired
);
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q >= limit);
endmodule

// File: rtl/bus_read_master.sv
module bus_read_master
  import brm_pkg::*;
#(
  parameter int AW          = 24,
  parameter int DW          = 16,
  parameter int WW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_fc,
  input  logic          req_word,
  input  logic [WW-1:0] wait_limit,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [1:0]    rsp_status,
  output logic          bus_clk,
  output logic [2:0]    bus_fc,
  output logic          bus_rw,
  output logic [AW-2:0] bus_addr,
  output logic          bus_addr_oe,
  output logic          bus_as_n,
  output logic          bus_uds_n,
  output logic          bus_lds_n,
  input  logic [DW-1:0] bus_data_in,
  input  logic          bus_dtack_n,
  input  logic          bus_berr_n,
  input  logic          bus_vpa_n
);
  localparam int BW = DW / 2;

  // Lane selection for a returned read.
  function automatic logic [DW-1:0] lane_pick(input logic [DW-1:0] d,
                                              input logic word, input logic a0);
    if (word) return d;
    return a0 ? {{BW{1'b0}}, d[BW-1:0]} : {{BW{1'b0}}, d[DW-1:BW]};
  endfunction

  brm_state_e    state_q, state_d;
  logic          clk_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    fc_q;
  logic          word_q;
  brm_rsp_e      stat_q;
  logic [DW-1:0] data_q;
  logic          rsp_valid_q;

  // Named internal events
  logic       accept;
  logic       decide;
  logic       term_ok, term_err, term_vpa;
  logic       expired;
  logic       decide_end;
  logic       latch_en;
  logic [2:0] sync_q;
  logic [1:0] strobe_en;

  brm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_vpa_n, bus_berr_n, bus_dtack_n}),
    .q     (sync_q)
  );

  assign term_ok  = !sync_q[0];
  assign term_err = !sync_q[1];
  assign term_vpa = !sync_q[2];

  assign req_ready  = (state_q == ST_IDLE) && !clk_q;
  assign accept     = req_valid && req_ready;
  assign decide     = (state_q == ST_S4) || (state_q == ST_WH);
  assign decide_end = term_ok || term_err || term_vpa || expired;
  assign latch_en   = (state_q == ST_S6);

  brm_wait_timer #(.WW(WW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .inc     (decide && !decide_end),
    .limit   (wait_limit),
    .expired (expired)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_S0;
      ST_S0:   state_d = ST_S1;
      ST_S1:   state_d = ST_S2;
      ST_S2:   state_d = ST_S3;
      ST_S3:   state_d = ST_S4;
      ST_S4,
      ST_WH:   state_d = decide_end ? ST_S5 : ST_WL;
      ST_WL:   state_d = ST_WH;
      ST_S5:   state_d = ST_S6;
      ST_S6:   state_d = ST_S7;
      ST_S7:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      clk_q       <= 1'b0;
      addr_q      <= '0;
      fc_q        <= '0;
      word_q      <= 1'b0;
      stat_q      <= RSP_OK;
      data_q      <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      clk_q       <= !clk_q;
      rsp_valid_q <= (state_q == ST_S7);
      if (accept) begin
        addr_q <= req_addr;
        fc_q   <= req_fc;
        word_q <= req_word;
      end
      if (decide && decide_end)
        stat_q <= term_status(term_err, term_ok, term_vpa);
      if (latch_en)
        data_q <= (stat_q == RSP_OK) ? lane_pick(bus_data_in, word_q, addr_q[0]) : '0;
    end
  end

  assign strobe_en   = strobe_pick(word_q, addr_q[0]);
  assign bus_clk     = clk_q;
  assign bus_rw      = 1'b1;
  assign bus_fc      = (state_q == ST_IDLE) ? 3'd0 : fc_q;
  assign bus_addr    = addr_q[AW-1:1];
  assign bus_addr_oe = (state_q != ST_IDLE) && (state_q != ST_S0);
  assign bus_as_n    = !strobe_window(state_q);
  assign bus_uds_n   = !(strobe_window(state_q) && strobe_en[1]);
  assign bus_lds_n   = !(strobe_window(state_q) && strobe_en[0]);
  assign rsp_valid   = rsp_valid_q;
  assign rsp_data    = data_q;
  assign rsp_status  = stat_q;
endmodule

// File: rtl/brm_checker.sv
module brm_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [1:0]    rsp_status,
  input logic [DW-1:0] rsp_data,
  input logic          bus_clk,
  input logic          bus_addr_oe,
  input logic          bus_as_n,
  input logic          bus_uds_n,
  input logic          bus_lds_n,
  input logic          decide
);
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_as_n && !bus_addr_oe && !bus_clk)); // R1
  AST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bus_clk != $past(bus_clk))); // R2
  AST_DECIDE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    decide |-> (bus_clk && !bus_as_n)); // R7
  AST_AS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as_n |-> bus_addr_oe); // R4
  AST_AS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as_n |-> (!bus_uds_n || !bus_lds_n)); // R6
  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as_n |-> (bus_uds_n && bus_lds_n)); // R5
  AST_RSP_AFTER_AS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_n) |=> rsp_valid); // R12
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R12
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'd3)); // R8
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_data == '0)); // R11
endmodule

bind bus_read_master brm_checker #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_status  (rsp_status),
  .rsp_data    (rsp_data),
  .bus_clk     (bus_clk),
  .bus_addr_oe (bus_addr_oe),
  .bus_as_n    (bus_as_n),
  .bus_uds_n   (bus_uds_n),
  .bus_lds_n   (bus_lds_n),
  .decide      (decide)
);

// File: tb/bus_read_master_tb.sv
module bus_read_master_tb;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int WW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [2:0]    req_fc = '0;
  logic          req_word = 1'b0;
  logic [WW-1:0] wait_limit = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [1:0]    rsp_status;
  logic          bus_clk, bus_rw, bus_addr_oe, bus_as_n, bus_uds_n, bus_lds_n;
  logic [2:0]    bus_fc;
  logic [AW-2:0] bus_addr;
  logic [DW-1:0] bus_data_in = '0;
  logic          bus_dtack_n = 1'b1;
  logic          bus_berr_n = 1'b1;
  logic          bus_vpa_n = 1'b1;

  always #2 clk = ~clk; // 250 MHz

  bus_read_master #(.AW(AW), .DW(DW), .WW(WW)) u_dut (.*);

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 acknowledge, 1 bus error, 2 peripheral, 3 none, 4 error+acknowledge
  typedef struct packed {
    logic [23:0] addr;
    logic        word;
    logic [2:0]  fc;
    logic [3:0]  dly;
    logic [2:0]  kind;
    logic [15:0] data;
    logic [7:0]  lim;
    logic [1:0]  est;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{24'h001000, 1'b1, 3'd5, 4'd0, 3'd0, 16'hA55A, 8'd8, 2'd0},
    '{24'h002001, 1'b0, 3'd1, 4'd3, 3'd0, 16'h1234, 8'd8, 2'd0},
    '{24'h002002, 1'b0, 3'd2, 4'd4, 3'd0, 16'hBEEF, 8'd8, 2'd0},
    '{24'h0030F0, 1'b1, 3'd6, 4'd1, 3'd1, 16'h7777, 8'd8, 2'd1},
    '{24'h004000, 1'b1, 3'd6, 4'd2, 3'd2, 16'h5555, 8'd8, 2'd2},
    '{24'h005554, 1'b1, 3'd2, 4'd0, 3'd3, 16'h9999, 8'd3, 2'd1},
    '{24'h00AAA8, 1'b1, 3'd1, 4'd0, 3'd4, 16'h4242, 8'd8, 2'd1},
    '{24'h00F00E, 1'b1, 3'd5, 4'd6, 3'd0, 16'h1111, 8'd2, 2'd1},
    '{24'h010203, 1'b0, 3'd5, 4'd5, 3'd0, 16'hC3A5, 8'd3, 2'd0},
    '{24'h7FFFFE, 1'b1, 3'd7, 4'd0, 3'd0, 16'h0F0F, 8'd0, 2'd0}
  };

  // Slave model
  logic [2:0]    cur_kind = 3'd3;
  int            cur_dly  = 0;
  int            low_cnt  = 0;
  logic          seen_uds, seen_lds, seen_rw;
  logic [AW-2:0] seen_addr;
  logic [2:0]    seen_fc;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !bus_as_n) begin
        low_cnt++;
        if (low_cnt == 1) begin
          seen_uds  = bus_uds_n;
          seen_lds  = bus_lds_n;
          seen_addr = bus_addr;
          seen_fc   = bus_fc;
          seen_rw   = bus_rw;
        end
        if (low_cnt > cur_dly) begin
          bus_dtack_n = !(cur_kind == 3'd0 || cur_kind == 3'd4);
          bus_berr_n  = !(cur_kind == 3'd1 || cur_kind == 3'd4);
          bus_vpa_n   = !(cur_kind == 3'd2);
        end
      end else begin
        low_cnt     = 0;
        bus_dtack_n = 1'b1;
        bus_berr_n  = 1'b1;
        bus_vpa_n   = 1'b1;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  function automatic int exp_waits(input vec_t v);
    int need;
    need = (int'(v.dly) + 1) / 2;
    if (v.kind == 3'd3) return int'(v.lim);
    return (need > int'(v.lim)) ? int'(v.lim) : need;
  endfunction

  function automatic logic [15:0] exp_data(input vec_t v);
    if (v.est != 2'd0) return 16'h0;
    if (v.word) return v.data;
    return v.addr[0] ? {8'h00, v.data[7:0]} : {8'h00, v.data[15:8]};
  endfunction

  task automatic run_vec(input vec_t v);
    int n;
    int w;
    logic prev_as, prev_oe;
    @(negedge clk);
    cur_kind    = v.kind;
    cur_dly     = int'(v.dly);
    bus_data_in = v.data;
    wait_limit  = v.lim;
    req_addr    = v.addr;
    req_fc      = v.fc;
    req_word    = v.word;
    req_valid   = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    chk(bus_clk == 1'b1, "R2 bus clock high in S0", bus_clk, 1);
    chk(bus_fc == v.fc && bus_addr_oe == 1'b0, "R3 fc in S0, address off", {bus_fc, bus_addr_oe}, {v.fc, 1'b0});
    prev_as = bus_as_n;
    prev_oe = bus_addr_oe;
    while (!rsp_valid && n < 100) begin
      prev_as = bus_as_n;
      prev_oe = bus_addr_oe;
      @(negedge clk);
      n++;
      if (n == 4) chk(req_ready == 1'b0, "R1 ready low while busy", req_ready, 0);
    end
    w = exp_waits(v);
    chk(n == 9 + 2 * w, "R7 response latency", n, 9 + 2 * w);
    chk(rsp_status == v.est, "R8 R9 R10 status", rsp_status, v.est);
    chk(rsp_data == exp_data(v), "R11 data", rsp_data, exp_data(v));
    chk(prev_as == 1'b1 && prev_oe == 1'b1, "R5 S7 strobe high, address on", {prev_as, prev_oe}, 2'b11);
    chk(bus_addr_oe == 1'b0, "R4 address off after S7", bus_addr_oe, 0);
    chk({seen_uds, seen_lds} == (v.word ? 2'b00 : (v.addr[0] ? 2'b10 : 2'b01)),
        "R6 strobe select", {seen_uds, seen_lds},
        v.word ? 2'b00 : (v.addr[0] ? 2'b10 : 2'b01));
    chk(seen_addr == v.addr[23:1] && seen_fc == v.fc && seen_rw == 1'b1,
        "R3 R4 address fc rw", {seen_addr, seen_fc, seen_rw}, {v.addr[23:1], v.fc, 1'b1});
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12 single pulse", rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_as_n && bus_uds_n && bus_lds_n, "R5 reset strobes high", {bus_as_n, bus_uds_n, bus_lds_n}, 3'b111);
    chk(!bus_addr_oe && bus_fc == 3'd0, "R4 reset address off", {bus_addr_oe, bus_fc}, 4'd0);
    chk(!rsp_valid, "R12 reset no response", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == !bus_clk, "R1 ready follows idle low phase", req_ready, !bus_clk);
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    // Back-to-back: second request accepted right after a response
    run_vec(VECS[0]);
    run_vec(VECS[1]);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule